// File: doc/BRIEF.md
# Compressed Program-Counter Trace Encoder

The block watches the stream of executed opcodes and turns their program counters into 20-bit trace rows for a trace memory. Each row has a 2-bit tag and an 18-bit payload. Illegal opcodes are recorded like any other opcode. While execution stays inside one 64-byte block, only the low six bits of each PC are kept. Up to three of these fields are packed into one row, so the memory holds more history. When execution moves to a different 64-byte block, a row with the full 18-bit PC is written. The first opcode recorded after arming also produces a full row. A decoder can therefore rebuild the complete PC sequence from the rows alone.

Tracing runs while `arm_i` is high. Dropping `arm_i` stops tracing and pushes out any partly filled row. A `flush_i` pulse does the same without stopping tracing.

A full row may be needed while a partial row is still pending. In that case both rows are written in the same cycle on two write lanes. Lane 0 always holds the older row. Rows appear on the outputs one clock after the input that causes them.

Top module: `pc_trace_enc`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `row_we_o` is 2'b00.
- R2: Decoding the rows in write order (lane 0 before lane 1) gives back exactly the PCs of the cycles where `arm_i` and `op_vld_i` were both high, in order, with none missing or added.
- R3: Each row has the tag in bits [19:18] and the payload in bits [17:0]. Tag 11 marks a full row, and its payload is the whole PC.
- R4: A packed row holds the low six PC bits of consecutive opcodes. The first opcode goes in bits [5:0], the second in [11:6] and the third in [17:12]; unused slots are zero. The tag gives the field count: 01 means one, 10 means two, 00 means three. A row becomes full on its third field and is written one clock after that opcode.
- R5: An opcode whose PC bits [17:6] differ from those of the last full row is written as a full row.
- R6: The first opcode recorded after `arm_i` rises, or after reset, is written as a full row.
- R7: When a full row is due and a partial row is pending, the partial row goes out on lane 0 and the full row on lane 1 in the same cycle (`row_we_o`=2'b11). Lane 1 is written only together with lane 0, and only with tag 11.
- R8: A `flush_i` pulse writes the pending partial row one clock later. If the same cycle's opcode was packed, its field is included in that row. With nothing pending, `flush_i` writes nothing.
- R9: A cycle with `arm_i` low after a cycle with it high acts as a flush. Opcodes presented while `arm_i` is low are ignored and produce no row.
- R10: Rows are written only one clock after a recorded opcode, a flush, or a stop. In any other cycle `row_we_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Tracing enable; high records opcodes, falling edge stops |
| op_vld_i | input | 1 | An opcode executed this cycle |
| op_pc_i | input | 18 | PC of that opcode |
| flush_i | input | 1 | Push out the pending partial row |
| row_we_o | output | 2 | Write strobes; bit 0 for lane 0, bit 1 for lane 1 |
| row0_o | output | 20 | Lane 0 row, the older row when both lanes write |
| row1_o | output | 20 | Lane 1 row, always a full PC row |

## Verification
Two events can fall in the same cycle and need an order between them. The first is a block crossing that meets a pending partial row, which must give a partial row on lane 0 and a full row on lane 1. The second is a packed opcode that arrives with `flush_i` or with the fall of `arm_i`; the flush must then include that opcode, or ignore it when arming has dropped. Directed sequences force each of these cases. Random stimulus mixes short PC steps with jumps, and adds frequent flush and arm toggles. A bench model predicts the exact lanes and payload each cycle, and a bench decoder rebuilds the PC stream and compares it with the recorded opcodes.

// File: rtl/pct_pkg.sv
package pct_pkg;
  typedef enum logic [1:0] {
    TAG_THREE = 2'b00,
    TAG_ONE   = 2'b01,
    TAG_TWO   = 2'b10,
    TAG_FULL  = 2'b11
  } pct_tag_e;

  function automatic pct_tag_e tag_for_count(input logic [1:0] n);
    case (n)
      2'd1:    return TAG_ONE;
      2'd2:    return TAG_TWO;
      default: return TAG_THREE;
    endcase
  endfunction
endpackage

// File: rtl/pct_blk_track.sv
module pct_blk_track #(
  parameter int BLK_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             load_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             miss_o
);
  logic             have_q, have_n;
  logic [BLK_W-1:0] ref_q, ref_n;

  always_comb begin
    miss_o = !have_q || (blk_i != ref_q);
    have_n = have_q;
    ref_n  = ref_q;
    if (load_i) begin
      have_n = 1'b1;
      ref_n  = blk_i;
    end
    if (!arm_i) have_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) have_q <= 1'b0;
    else        have_q <= have_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= '0;
    else if (load_i) ref_q <= ref_n;
  end
endmodule

// File: rtl/pct_packer.sv
module pct_packer #(
  parameter int LO_W  = 6,
  parameter int SLOTS = 3,
  parameter int CW    = $clog2(SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ins_i,
  input  logic [LO_W-1:0]       lo_i,
  input  logic                  drain_i,
  input  logic                  flush_i,
  output logic                  emit_o,
  output logic [CW-1:0]         emit_cnt_o,
  output logic [SLOTS*LO_W-1:0] emit_pack_o
);
  localparam int PW = SLOTS * LO_W;

  logic [CW-1:0] cnt_q, cnt_n, cnt_ins;
  logic [PW-1:0] pack_q, pack_n, pack_ins, pack_sel;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign pack_ins[s*LO_W +: LO_W] = (ins_i && cnt_q == CW'(s)) ? lo_i : pack_q[s*LO_W +: LO_W];
    assign emit_pack_o[s*LO_W +: LO_W] = (emit_cnt_o > CW'(s)) ? pack_sel[s*LO_W +: LO_W] : '0;
  end

  always_comb begin
    cnt_ins = cnt_q + CW'(ins_i);
    if (drain_i) begin
      emit_o     = (cnt_q != '0);
      emit_cnt_o = cnt_q;
      pack_sel   = pack_q;
      cnt_n      = '0;
      pack_n     = pack_q;
    end else begin
      emit_o     = (cnt_ins != '0) && ((cnt_ins == CW'(SLOTS)) || flush_i);
      emit_cnt_o = cnt_ins;
      pack_sel   = pack_ins;
      cnt_n      = emit_o ? '0 : cnt_ins;
      pack_n     = pack_ins;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pack_q <= '0;
    else if (ins_i) pack_q <= pack_n;
  end
endmodule

// File: rtl/pc_trace_enc.sv
module pc_trace_enc #(
  parameter int PC_W  = 18,
  parameter int LO_W  = 6,
  parameter int SLOTS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm_i,
  input  logic            op_vld_i,
  input  logic [PC_W-1:0] op_pc_i,
  input  logic            flush_i,
  output logic [1:0]      row_we_o,
  output logic [PC_W+1:0] row0_o,
  output logic [PC_W+1:0] row1_o
);
  import pct_pkg::*;
  localparam int BLK_W = PC_W - LO_W;
  localparam int CW    = $clog2(SLOTS + 1);
  localparam int ROW_W = PC_W + 2;

  logic            armed_q;
  logic            rec, stop, flush_req, miss, need_full, pack_ins;
  logic            emit;
  logic [CW-1:0]   emit_cnt;
  logic [PC_W-1:0] emit_pack;
  logic [1:0]      we_n;
  logic [ROW_W-1:0] r0_n, r1_n, full_row, part_row;

  assign rec       = arm_i && op_vld_i;
  assign stop      = armed_q && !arm_i;
  assign flush_req = flush_i || stop;
  assign need_full = rec && miss;
  assign pack_ins  = rec && !miss;

  pct_blk_track #(.BLK_W(BLK_W)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (arm_i),
    .load_i (need_full),
    .blk_i  (op_pc_i[PC_W-1:LO_W]),
    .miss_o (miss)
  );

  pct_packer #(.LO_W(LO_W), .SLOTS(SLOTS), .CW(CW)) u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_i       (pack_ins),
    .lo_i        (op_pc_i[LO_W-1:0]),
    .drain_i     (need_full),
    .flush_i     (flush_req),
    .emit_o      (emit),
    .emit_cnt_o  (emit_cnt),
    .emit_pack_o (emit_pack)
  );

  always_comb begin
    full_row = {TAG_FULL, op_pc_i};
    part_row = {tag_for_count(2'(emit_cnt)), emit_pack};
    we_n     = 2'b00;
    r0_n     = part_row;
    r1_n     = full_row;
    if (emit && need_full) begin
      we_n = 2'b11;
    end else if (emit) begin
      we_n = 2'b01;
    end else if (need_full) begin
      we_n = 2'b01;
      r0_n = full_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      row_we_o <= 2'b00;
    end else begin
      armed_q  <= arm_i;
      row_we_o <= we_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row0_o <= '0;
    else if (we_n[0]) row0_o <= r0_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row1_o <= '0;
    else if (we_n[1]) row1_o <= r1_n;
  end
endmodule

// File: rtl/pct_chk.sv
module pct_chk #(
  parameter int PC_W = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            arm_i,
  input logic            op_vld_i,
  input logic [PC_W-1:0] op_pc_i,
  input logic            flush_i,
  input logic [1:0]      row_we_o,
  input logic [PC_W+1:0] row0_o,
  input logic [PC_W+1:0] row1_o
);
  // R7
  lane1_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_we_o[1] |-> (row_we_o[0] && row1_o[PC_W+1:PC_W] == 2'b11));

  // R7
  lane0_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_we_o[1] |-> (row0_o[PC_W+1:PC_W] == 2'b01 || row0_o[PC_W+1:PC_W] == 2'b10));

  // R6
  first_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && op_vld_i && !$past(arm_i)) |=>
      (row_we_o == 2'b01 && row0_o[PC_W+1:PC_W] == 2'b11 && row0_o[PC_W-1:0] == $past(op_pc_i)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(arm_i && op_vld_i) && !flush_i && (arm_i || !$past(arm_i))) |=> (row_we_o == 2'b00));

  // R9
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_i && !$past(arm_i) && !flush_i) |=> (row_we_o == 2'b00));
endmodule

bind pc_trace_enc pct_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/tb_pc_trace_enc.sv
module tb_pc_trace_enc;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, arm_i, op_vld_i, flush_i;
  logic [17:0] op_pc_i;
  logic [1:0]  row_we_o;
  logic [19:0] row0_o, row1_o;

  int checks, failures;

  pc_trace_enc dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model state
  int          m_cnt;
  logic [17:0] m_pack;
  logic [11:0] m_ref;
  logic        m_have, m_armq;
  logic [19:0] e_row [2];
  int          e_n;
  // decoder state
  logic [17:0] rec_q [$];
  logic [11:0] d_blk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] part_row(input int n, input logic [17:0] p);
    logic [1:0] t;
    logic [17:0] m;
    t = (n == 1) ? 2'b01 : (n == 2) ? 2'b10 : 2'b00;
    m = (n == 1) ? {12'd0, p[5:0]} : (n == 2) ? {6'd0, p[11:0]} : p;
    return {t, m};
  endfunction

  task automatic model(input logic arm, input logic vld, input logic [17:0] pc, input logic fl);
    logic rec, fr;
    rec = arm && vld;
    fr  = fl || (m_armq && !arm);
    e_n = 0;
    if (rec) begin
      rec_q.push_back(pc);
      if (!m_have || pc[17:6] != m_ref) begin
        if (m_cnt > 0) begin e_row[e_n] = part_row(m_cnt, m_pack); e_n++; end
        e_row[e_n] = {2'b11, pc}; e_n++;
        m_cnt = 0; m_have = 1'b1; m_ref = pc[17:6];
      end else begin
        m_pack[m_cnt*6 +: 6] = pc[5:0];
        m_cnt++;
        if (m_cnt == 3 || fr) begin e_row[e_n] = part_row(m_cnt, m_pack); e_n++; m_cnt = 0; end
      end
    end else if (fr && m_cnt > 0) begin
      e_row[e_n] = part_row(m_cnt, m_pack); e_n++; m_cnt = 0;
    end
    if (!arm) m_have = 1'b0;
    m_armq = arm;
  endtask

  task automatic decode(input logic [19:0] r, input string req);
    int n;
    logic [17:0] exp_pc, got;
    if (r[19:18] == 2'b11) n = 1;
    else n = (r[19:18] == 2'b01) ? 1 : (r[19:18] == 2'b10) ? 2 : 3;
    for (int k = 0; k < n; k++) begin
      if (r[19:18] == 2'b11) begin got = r[17:0]; d_blk = r[17:6]; end
      else got = {d_blk, r[k*6 +: 6]};
      exp_pc = (rec_q.size() > 0) ? rec_q.pop_front() : 18'h3ffff;
      chk(got == exp_pc, req, 32'(got), 32'(exp_pc));
    end
  endtask

  task automatic step(input logic arm, input logic vld, input logic [17:0] pc, input logic fl, input string req);
    logic [1:0] ewe;
    arm_i = arm; op_vld_i = vld; op_pc_i = pc; flush_i = fl;
    model(arm, vld, pc, fl);
    @(posedge clk); #1;
    ewe = (e_n == 2) ? 2'b11 : (e_n == 1) ? 2'b01 : 2'b00;
    chk(row_we_o == ewe, {req, " R10 we"}, 32'(row_we_o), 32'(ewe));
    if (ewe[0]) chk(row0_o == e_row[0], {req, " R3 lane0"}, 32'(row0_o), 32'(e_row[0]));
    if (ewe[1]) chk(row1_o == e_row[1], {req, " R7 lane1"}, 32'(row1_o), 32'(e_row[1]));
    if (row_we_o[0]) decode(row0_o, "R2 decode");
    if (row_we_o[1]) decode(row1_o, "R2 decode");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [17:0] pc;
    checks = 0; failures = 0;
    m_cnt = 0; m_pack = '0; m_ref = '0; m_have = 1'b0; m_armq = 1'b0; e_n = 0; d_blk = '0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; arm_i = 1'b0; op_vld_i = 1'b0; op_pc_i = '0; flush_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(row_we_o == 2'b00, "R1 reset we", 32'(row_we_o), 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1");
    // ignored while unarmed
    step(0, 1, 18'h01234, 0, "R9 unarmed op");
    step(0, 0, 0, 1, "R8 empty flush");
    // first after arm is full
    step(1, 1, 18'h01240, 0, "R6 first");
    // three fields in block
    step(1, 1, 18'h01241, 0, "R4 slot0");
    step(1, 1, 18'h01243, 0, "R4 slot1");
    step(1, 1, 18'h0127f, 0, "R4 slot2 full pack");
    chk(row0_o == {2'b00, 6'h3f, 6'h03, 6'h01}, "R4 three-field row", 32'(row0_o), 32'({2'b00, 6'h3f, 6'h03, 6'h01}));
    // partial then crossing
    step(1, 1, 18'h01270, 0, "R4 one field");
    step(1, 1, 18'h01280, 0, "R5 R7 crossing");
    chk(row_we_o == 2'b11 && row0_o == {2'b01, 12'd0, 6'h30} && row1_o == {2'b11, 18'h01280},
        "R7 pair", 32'(row_we_o), 32'h3);
    // flush with packed op same cycle
    step(1, 1, 18'h01285, 0, "R8 pre");
    step(1, 1, 18'h01286, 1, "R8 flush incl op");
    chk(row0_o == {2'b10, 6'd0, 6'h06, 6'h05}, "R8 two-field row", 32'(row0_o), 32'({2'b10, 6'd0, 6'h06, 6'h05}));
    step(1, 0, 0, 1, "R8 empty flush armed");
    step(1, 0, 0, 0, "R10 idle");
    // disarm as flush, op ignored
    step(1, 1, 18'h01287, 0, "R9 pre");
    step(0, 1, 18'h01288, 0, "R9 stop");
    chk(row0_o == {2'b01, 12'd0, 6'h07}, "R9 stop row", 32'(row0_o), 32'({2'b01, 12'd0, 6'h07}));
    step(1, 1, 18'h01289, 0, "R6 rearm same block");
    chk(row0_o[19:18] == 2'b11, "R6 rearm full", 32'(row0_o[19:18]), 3);
    // random phase
    pc = 18'h00100;
    for (int i = 0; i < 20000; i++) begin
      logic arm, vld, fl;
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 8) pc = 18'($urandom());
      else pc = pc + 18'($urandom_range(1, 5));
      arm = ($urandom_range(0, 99) < 93);
      vld = ($urandom_range(0, 99) < 75);
      fl  = ($urandom_range(0, 99) < 6);
      step(arm, vld, pc, fl, "R2 random");
    end
    step(0, 0, 0, 0, "R9 final stop");
    step(0, 0, 0, 0, "R10 final idle");
    chk(rec_q.size() == 0, "R2 all decoded", 32'(rec_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule